// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the clocked digital front end of a two-channel 12-bit converter that is written from an 8-bit parallel bus. Each channel's code is split across two bus-addressed input registers: a low byte and a high nibble. A bus write needs chip-select and write strobe both low. A 2-bit address then chooses which of the four input registers takes the bus byte. The registers can be written in any order.

A second, independent load strobe moves both 12-bit input words into the two output (DAC) registers in the same clock. While it is low the output registers track the input words. When it rises they freeze. Software can therefore stage a new code pair and change both outputs at once, or hold the load strobe low so the outputs follow the writes.

Every strobe, the address and the data pass through a synchroniser of `SYNC_STAGES` flops before any decoding. A guard watches for a load pulse that overlaps a write. It raises a violation flag when the load strobe rises fewer than `MIN_LOAD` clocks after such a write ends.

Top module: `dual_dac_front`

## Requirements
- R1: A synchronous active-high reset clears all four input registers, both output codes and the violation flag to zero. After reset the load strobe is taken as high (outputs frozen).
- R2: With `sel_n` and `wr_n` both low, `bus_addr` selects the register. 2'b00 is the channel A low byte, 2'b01 the channel A high nibble, 2'b10 the channel B low byte and 2'b11 the channel B high nibble. The low byte lands in code bits 7:0.
- R3: A high-nibble write stores `bus_din[3:0]` into code bits 11:8 of the addressed channel. `bus_din[7:4]` has no effect.
- R4: While `sel_n` is high or `wr_n` is high, no input register changes, whatever the address and data are.
- R5: While the synchronised load strobe is high, both output codes hold, even across input-register writes.
- R6: While the synchronised load strobe is low, both output codes take their channel's input word one clock later. Both channels change in the same clock.
- R7: When the load strobe rises, the output codes keep the words they held at that moment until the strobe falls again.
- R8: The load strobe acts without any write activity. Lowering it alone transfers previously staged words.
- R9: Suppose a write occurs while the load strobe is low, and the strobe then rises after fewer than `MIN_LOAD` clocks with no write and the strobe low. Then `load_viol` goes high and stays high until the strobe next falls. With `MIN_LOAD` or more such clocks the flag stays low.
- R10: From the clock edge that first samples an input to the output register update, the path takes `SYNC_STAGES` + 1 edges for a write seen through a held-low load strobe. A load-strobe fall updates the outputs at the `SYNC_STAGES`-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_din | input | 8 | Right-justified bus data |
| bus_addr | input | 2 | Input register select |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| load_n | input | 1 | Transfer strobe to output registers, active low |
| chan_a_code | output | 12 | Channel A output register |
| chan_b_code | output | 12 | Channel B output register |
| load_viol | output | 1 | Load pulse ended too soon after an overlapping write |

## Verification
The properties are stated on the synchronised strobes. They assume every raw input stays steady for at least one clock, so that the synchroniser output is the raw input delayed by a fixed count of edges. The stimulus changes the bus, strobes and address only on the falling clock edge and holds each write for one full cycle. The bus data is also held until the write strobe is released. Overlap tests place the load rise a counted number of clocks after the write release, so that both sides of the `MIN_LOAD` boundary are reached.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   // Address field decode: bit 1 picks the channel, bit 0 picks the half.
   typedef enum logic [1:0] {
      SLOT_A_LO = 2'b00,
      SLOT_A_HI = 2'b01,
      SLOT_B_LO = 2'b10,
      SLOT_B_HI = 2'b11
   } slot_e;

   localparam int NUM_CH = 2;

   function automatic logic slot_is_high(input logic [1:0] a);
      return a[0];
   endfunction

   function automatic int slot_channel(input logic [1:0] a);
      return int'(a[1]);
   endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int          W       = 8,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= RST_VAL;
      else     stg[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[s] <= RST_VAL;
         else     stg[s] <= stg[s-1];
      end
   end

   assign d_out = stg[STAGES-1];
endmodule

// File: rtl/dacfe_inreg.sv
module dacfe_inreg
   import dacfe_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CODE_W = 12
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_act,
   input  logic [1:0]                     addr,
   input  logic [DATA_W-1:0]              data,
   output logic [NUM_CH-1:0][CODE_W-1:0]  words
);
   localparam int HI_W = CODE_W - DATA_W;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;
      logic              hit;

      assign hit = wr_act && (slot_channel(addr) == ch);

      always_ff @(posedge clk) begin
         if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (hit) begin
            if (slot_is_high(addr)) hi_q <= data[HI_W-1:0];
            else                    lo_q <= data;
         end
      end

      assign words[ch] = {hi_q, lo_q};
   end
endmodule

// File: rtl/dacfe_dacreg.sv
module dacfe_dacreg
   import dacfe_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          load_low,
   input  logic [NUM_CH-1:0][CODE_W-1:0] words,
   output logic [NUM_CH-1:0][CODE_W-1:0] codes
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk) begin
         if (rst)           codes[ch] <= '0;
         else if (load_low) codes[ch] <= words[ch];
      end
   end
endmodule

// File: rtl/dacfe_guard.sv
module dacfe_guard #(
   parameter int MIN_LOAD = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_act,
   input  logic load_low,
   output logic viol
);
   if (MIN_LOAD == 0) begin : g_off
      assign viol = 1'b0;
   end else begin : g_on
      localparam int CNT_W = $clog2(MIN_LOAD + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_LOAD);

      logic [CNT_W-1:0] cnt_q;
      logic             overlap_q;
      logic             prev_low_q;
      logic             viol_q;
      logic             rise;
      logic             fall;

      assign rise = !load_low && prev_low_q;
      assign fall = load_low && !prev_low_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q      <= '0;
            overlap_q  <= 1'b0;
            prev_low_q <= 1'b0;
            viol_q     <= 1'b0;
         end else begin
            prev_low_q <= load_low;

            if (wr_act)                         cnt_q <= '0;
            else if (load_low && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;

            if (wr_act && load_low) overlap_q <= 1'b1;
            else if (!load_low)     overlap_q <= 1'b0;

            if (rise)      viol_q <= overlap_q && (cnt_q < LIMIT);
            else if (fall) viol_q <= 1'b0;
         end
      end

      assign viol = viol_q;
   end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
   import dacfe_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOAD    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] bus_din,
   input  logic [1:0]        bus_addr,
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic              load_n,
   output logic [CODE_W-1:0] chan_a_code,
   output logic [CODE_W-1:0] chan_b_code,
   output logic              load_viol
);
   localparam int RAW_W = DATA_W + 5;
   localparam logic [RAW_W-1:0] RAW_IDLE = {3'b111, 2'b00, {DATA_W{1'b0}}};

   if (CODE_W <= DATA_W || CODE_W > 2 * DATA_W) begin : g_bad_width
      $error("dual_dac_front: CODE_W must lie in (DATA_W, 2*DATA_W]");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dual_dac_front: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOAD < 0) begin : g_bad_min
      $error("dual_dac_front: MIN_LOAD must not be negative");
   end

   logic [RAW_W-1:0] raw_in;
   logic [RAW_W-1:0] raw_sync;

   logic              load_sync;
   logic              sel_sync;
   logic              wr_sync;
   logic [1:0]        addr_sync;
   logic [DATA_W-1:0] data_sync;
   logic              write_en;

   logic [NUM_CH-1:0][CODE_W-1:0] words;
   logic [NUM_CH-1:0][CODE_W-1:0] codes;

   assign raw_in = {load_n, sel_n, wr_n, bus_addr, bus_din};

   dacfe_sync #(
      .W       (RAW_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (RAW_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  (raw_in),
      .d_out (raw_sync)
   );

   assign {load_sync, sel_sync, wr_sync, addr_sync, data_sync} = raw_sync;
   assign write_en = !sel_sync && !wr_sync;

   dacfe_inreg #(
      .DATA_W (DATA_W),
      .CODE_W (CODE_W)
   ) u_inreg (
      .clk    (clk),
      .rst    (rst),
      .wr_act (write_en),
      .addr   (addr_sync),
      .data   (data_sync),
      .words  (words)
   );

   dacfe_dacreg #(
      .CODE_W (CODE_W)
   ) u_dacreg (
      .clk      (clk),
      .rst      (rst),
      .load_low (!load_sync),
      .words    (words),
      .codes    (codes)
   );

   dacfe_guard #(
      .MIN_LOAD (MIN_LOAD)
   ) u_guard (
      .clk      (clk),
      .rst      (rst),
      .wr_act   (write_en),
      .load_low (!load_sync),
      .viol     (load_viol)
   );

   assign chan_a_code = codes[0];
   assign chan_b_code = codes[1];
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int DATA_W = 8,
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              load_sync,
   input logic              sel_sync,
   input logic              wr_sync,
   input logic [1:0]        addr_sync,
   input logic [DATA_W-1:0] data_sync,
   input logic [CODE_W-1:0] word_a,
   input logic [CODE_W-1:0] word_b,
   input logic [CODE_W-1:0] chan_a_code,
   input logic [CODE_W-1:0] chan_b_code,
   input logic              load_viol
);
   localparam int HI_W = CODE_W - DATA_W;

   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (chan_a_code == '0) && (chan_b_code == '0) && !load_viol);

   p_low_byte_a_r2: assert property (@(posedge clk) disable iff (rst)
      (!sel_sync && !wr_sync && addr_sync == 2'b00)
      |=> (word_a[DATA_W-1:0] == $past(data_sync)) && $stable(word_b));

   p_high_nibble_a_r3: assert property (@(posedge clk) disable iff (rst)
      (!sel_sync && !wr_sync && addr_sync == 2'b01)
      |=> (word_a[CODE_W-1:DATA_W] == $past(data_sync[HI_W-1:0]))
          && $stable(word_a[DATA_W-1:0]) && $stable(word_b));

   p_idle_bus_r4: assert property (@(posedge clk) disable iff (rst)
      (sel_sync || wr_sync) |=> $stable(word_a) && $stable(word_b));

   p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
      load_sync |=> $stable(chan_a_code) && $stable(chan_b_code));

   p_follow_low_r6: assert property (@(posedge clk) disable iff (rst)
      !load_sync |=> (chan_a_code == $past(word_a)) && (chan_b_code == $past(word_b)));

   p_viol_clear_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(load_sync) |=> !load_viol);

   p_viol_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(load_viol) |-> $past(load_sync) && !$past(load_sync, 2));
endmodule

bind dual_dac_front dacfe_checker #(
   .DATA_W (DATA_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .load_sync   (load_sync),
   .sel_sync    (sel_sync),
   .wr_sync     (wr_sync),
   .addr_sync   (addr_sync),
   .data_sync   (data_sync),
   .word_a      (words[0]),
   .word_b      (words[1]),
   .chan_a_code (chan_a_code),
   .chan_b_code (chan_b_code),
   .load_viol   (load_viol)
);

// File: tb/dual_dac_front_bench.sv
module dual_dac_front_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  bus_din;
   logic [1:0]  bus_addr;
   logic        sel_n;
   logic        wr_n;
   logic        load_n;
   logic [11:0] chan_a_code;
   logic [11:0] chan_b_code;
   logic        load_viol;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_dac_front u_dual_dac_front (
      .clk         (clk),
      .rst         (rst),
      .bus_din     (bus_din),
      .bus_addr    (bus_addr),
      .sel_n       (sel_n),
      .wr_n        (wr_n),
      .load_n      (load_n),
      .chan_a_code (chan_a_code),
      .chan_b_code (chan_b_code),
      .load_viol   (load_viol)
   );

   // {addr, data, expected A, expected B} with the load strobe held low
   localparam logic [33:0] VEC [8] = '{
      {2'd0, 8'h5A, 12'h05A, 12'h000},
      {2'd1, 8'hF3, 12'h35A, 12'h000},
      {2'd2, 8'hC7, 12'h35A, 12'h0C7},
      {2'd3, 8'h09, 12'h35A, 12'h9C7},
      {2'd1, 8'h0E, 12'hE5A, 12'h9C7},
      {2'd0, 8'h00, 12'hE00, 12'h9C7},
      {2'd3, 8'hAB, 12'hE00, 12'hBC7},
      {2'd2, 8'hFF, 12'hE00, 12'hBFF}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_din  = d;
      sel_n    = 1'b0;
      wr_n     = 1'b0;
      @(negedge clk);
      sel_n    = 1'b1;
      wr_n     = 1'b1;
   endtask

   task automatic overlap_pulse(input int gap);
      bus_write(2'd3, 8'h05);
      wait_neg(gap);
      load_n = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      wait_neg(WATCHDOG);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         summary();
      end
   end

   initial begin
      rst = 1'b1; bus_din = '0; bus_addr = '0;
      sel_n = 1'b1; wr_n = 1'b1; load_n = 1'b0;
      wait_neg(3);
      rst = 1'b0;
      check("R1 reset A", chan_a_code, 12'h000);
      check("R1 reset B", chan_b_code, 12'h000);
      check("R1 reset viol", load_viol, 1'b0);

      // R2 R3 R10: table walk with outputs following the writes
      for (int i = 0; i < 8; i++) begin
         bus_write(VEC[i][33:32], VEC[i][31:24]);
         wait_neg(2);
         check("R10 not yet A", chan_a_code, (i == 0) ? 12'h000 : VEC[i-1][23:12]);
         wait_neg(1);
         check("R2/R3 vector A", chan_a_code, VEC[i][23:12]);
         check("R2/R3 vector B", chan_b_code, VEC[i][11:0]);
      end

      // R4: half-asserted strobes do nothing
      @(negedge clk); bus_addr = 2'd0; bus_din = 8'h11; sel_n = 1'b1; wr_n = 1'b0;
      @(negedge clk); bus_addr = 2'd2; bus_din = 8'h22; sel_n = 1'b0; wr_n = 1'b1;
      @(negedge clk); sel_n = 1'b1;
      wait_neg(4);
      check("R4 A unchanged", chan_a_code, 12'hE00);
      check("R4 B unchanged", chan_b_code, 12'hBFF);

      // R5: writes staged while load is high do not reach outputs
      load_n = 1'b1;
      wait_neg(4);
      bus_write(2'd0, 8'h77);
      bus_write(2'd2, 8'h33);
      wait_neg(4);
      check("R5 A held", chan_a_code, 12'hE00);
      check("R5 B held", chan_b_code, 12'hBFF);

      // R6 R8 R10: load alone transfers both words in the same clock
      load_n = 1'b0;
      wait_neg(2);
      check("R6 A before", chan_a_code, 12'hE00);
      check("R6 B before", chan_b_code, 12'hBFF);
      wait_neg(1);
      check("R8 A after", chan_a_code, 12'hE77);
      check("R6 B after", chan_b_code, 12'hB33);

      // R7: freeze on rise
      bus_write(2'd1, 8'h02);
      wait_neg(4);
      check("R2 A follow", chan_a_code, 12'h277);
      load_n = 1'b1;
      bus_write(2'd0, 8'h99);
      wait_neg(4);
      check("R7 A frozen", chan_a_code, 12'h277);
      check("R9 long gap no viol", load_viol, 1'b0);
      load_n = 1'b0;
      wait_neg(4);
      check("R8 A released", chan_a_code, 12'h299);

      // R9: overlap boundary
      overlap_pulse(2);
      wait_neg(4);
      check("R9 short gap viol", load_viol, 1'b1);
      check("R7 B frozen", chan_b_code, 12'h533);
      load_n = 1'b0;
      wait_neg(4);
      check("R9 cleared on fall", load_viol, 1'b0);
      overlap_pulse(3);
      wait_neg(4);
      check("R9 exact gap no viol", load_viol, 1'b0);
      load_n = 1'b0;
      wait_neg(4);
      overlap_pulse(0);
      wait_neg(4);
      check("R9 zero gap viol", load_viol, 1'b1);

      // R1: reset mid-run
      load_n = 1'b0;
      rst = 1'b1;
      wait_neg(1);
      rst = 1'b0;
      check("R1 mid A", chan_a_code, 12'h000);
      check("R1 mid B", chan_b_code, 12'h000);
      check("R1 mid viol", load_viol, 1'b0);
      wait_neg(4);
      check("R1 inputs cleared A", chan_a_code, 12'h000);
      check("R1 inputs cleared B", chan_b_code, 12'h000);

      done = 1'b1;
      summary();
   end
endmodule